// File: doc/BRIEF.md
# Floating-Point Add/Subtract Alignment Front End

This block is the first half of a pipelined floating-point adder/subtracter for a simplified binary format: one sign bit, an excess-coded exponent and a fraction with a hidden leading one. It takes two operands and an add/subtract control. It orders the operands by magnitude and restores the hidden one on non-zero operands. It then shifts the smaller mantissa right until both exponents agree, and adds or subtracts the two magnitudes. The result is a sign, the larger exponent and an unnormalised magnitude with one spare bit for the carry. A downstream normaliser turns these into a packed number. The block does no normalisation or rounding, and it has no handling for denormals, NaN or infinity.

The block has three register stages: compare/swap, align, and add/subtract. It accepts a new operand pair on every cycle. A valid flag moves with each pair, so bubbles in the input stream stay bubbles at the output. The exponent and fraction widths are parameters. The default is an 8-bit exponent with a 23-bit fraction, and a 10-bit exponent with a 15-bit fraction is equally legal.

Top module: `fpa_front`

## Requirements
- R1: An operand is packed as {sign, exponent[EXP_W-1:0], fraction[FRAC_W-1:0]}, with the sign at bit EXP_W+FRAC_W. EXP_W=8/FRAC_W=23 is the default, and EXP_W=10/FRAC_W=15 is also supported.
- R2: An operand whose exponent field is 0 is zero: its mantissa is 0 whatever its fraction field holds. Any other operand has the mantissa {1, fraction}, which is MANT_W=FRAC_W+1 bits wide.
- R3: op_sub=0 adds the operands. op_sub=1 subtracts opb from opa by inverting the sign of opb before anything else happens.
- R4: The operand with the larger magnitude is chosen by comparing {exponent, fraction}, and res_exp is that operand's exponent field.
- R5: The smaller mantissa is shifted right by the exponent difference, and bits shifted out are dropped. A difference of MANT_W or more gives an aligned mantissa of 0.
- R6: With equal effective signs, res_mag is larger mantissa + aligned smaller mantissa. With different signs, res_mag is larger − aligned smaller, which is never negative. res_mag is MANT_W+1 bits wide.
- R7: res_sign is the effective sign of the larger operand, except that res_sign is 0 whenever res_mag is 0.
- R8: res_valid is high exactly three clock cycles after a cycle with in_valid high, and low otherwise. A pair presented with in_valid low produces no output.
- R9: While rst_n is low, res_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| op_sub | input | 1 | 0 = add, 1 = subtract opb from opa |
| opa | input | 1+EXP_W+FRAC_W | First operand |
| opb | input | 1+EXP_W+FRAC_W | Second operand |
| res_valid | output | 1 | Result present |
| res_sign | output | 1 | Result sign |
| res_exp | output | EXP_W | Exponent of the larger operand |
| res_mag | output | FRAC_W+2 | Unnormalised magnitude, carry bit at the top |

## Verification
The hardest cases to reach from the ports are those where several conditions meet. In one, the exponent difference lands exactly on or past the mantissa width, so the small operand vanishes entirely. In another, an effective subtraction of equal magnitudes must come out as zero with a positive sign. In a third, a zero operand carries a non-zero fraction field. With the default widths these are a thin slice of a huge space, so the bench builds a second instance with a 3-bit exponent and a 3-bit fraction. It sweeps every operand pair in both operations through that instance, back to back and with periodic bubbles. Every one of those meetings, including differences of 4 to 6 against a 4-bit mantissa, is reached by construction. A short directed set on the 10/15 instance covers the wide shift boundary.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } fpa_op_e;
endpackage

// File: rtl/fpa_cmp_swap.sv
module fpa_cmp_swap
    import fpa_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      op_sub,
    input  logic [EXP_W+FRAC_W:0]     opa,
    input  logic [EXP_W+FRAC_W:0]     opb,
    output logic                      s1_valid,
    output logic                      s1_sign,
    output logic                      s1_eff_sub,
    output logic [EXP_W-1:0]          s1_exp_big,
    output logic [EXP_W-1:0]          s1_exp_diff,
    output logic [FRAC_W:0]           s1_mant_big,
    output logic [FRAC_W:0]           s1_mant_small
);
    localparam int MANT_W = FRAC_W + 1;
    localparam int OP_W   = 1 + EXP_W + FRAC_W;

    typedef struct packed {
        logic              valid;
        logic              sign;
        logic              eff_sub;
        logic [EXP_W-1:0]  exp_big;
        logic [EXP_W-1:0]  exp_diff;
        logic [MANT_W-1:0] mant_big;
        logic [MANT_W-1:0] mant_small;
    } s1_t;

    s1_t s1_d, s1_q;

    logic              sgn_a, sgn_b, b_larger;
    logic [EXP_W-1:0]  exp_a, exp_b, exp_small;
    logic [FRAC_W-1:0] frc_a, frc_b;
    logic [MANT_W-1:0] man_a, man_b;

    always_comb begin
        sgn_a = opa[OP_W-1];
        sgn_b = opb[OP_W-1] ^ (op_sub == OP_SUB);
        exp_a = opa[OP_W-2 -: EXP_W];
        exp_b = opb[OP_W-2 -: EXP_W];
        frc_a = opa[FRAC_W-1:0];
        frc_b = opb[FRAC_W-1:0];
        // hidden one only for a non-zero operand; zero exponent flushes the fraction
        man_a = (exp_a != '0) ? {1'b1, frc_a} : '0;
        man_b = (exp_b != '0) ? {1'b1, frc_b} : '0;
        b_larger = {exp_b, frc_b} > {exp_a, frc_a};

        s1_d.valid      = in_valid;
        s1_d.eff_sub    = sgn_a ^ sgn_b;
        s1_d.sign       = b_larger ? sgn_b : sgn_a;
        s1_d.exp_big    = b_larger ? exp_b : exp_a;
        exp_small       = b_larger ? exp_a : exp_b;
        s1_d.exp_diff   = s1_d.exp_big - exp_small;
        s1_d.mant_big   = b_larger ? man_b : man_a;
        s1_d.mant_small = b_larger ? man_a : man_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s1_q <= '0;
        else        s1_q <= s1_d;
    end

    assign s1_valid      = s1_q.valid;
    assign s1_sign       = s1_q.sign;
    assign s1_eff_sub    = s1_q.eff_sub;
    assign s1_exp_big    = s1_q.exp_big;
    assign s1_exp_diff   = s1_q.exp_diff;
    assign s1_mant_big   = s1_q.mant_big;
    assign s1_mant_small = s1_q.mant_small;
endmodule

// File: rtl/fpa_align.sv
module fpa_align #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s1_valid,
    input  logic              s1_sign,
    input  logic              s1_eff_sub,
    input  logic [EXP_W-1:0]  s1_exp_big,
    input  logic [EXP_W-1:0]  s1_exp_diff,
    input  logic [FRAC_W:0]   s1_mant_big,
    input  logic [FRAC_W:0]   s1_mant_small,
    output logic              s2_valid,
    output logic              s2_sign,
    output logic              s2_eff_sub,
    output logic [EXP_W-1:0]  s2_exp_big,
    output logic [FRAC_W:0]   s2_mant_big,
    output logic [FRAC_W:0]   s2_mant_small
);
    localparam int MANT_W = FRAC_W + 1;

    typedef struct packed {
        logic              valid;
        logic              sign;
        logic              eff_sub;
        logic [EXP_W-1:0]  exp_big;
        logic [MANT_W-1:0] mant_big;
        logic [MANT_W-1:0] mant_small;
    } s2_t;

    s2_t s2_d, s2_q;

    always_comb begin
        s2_d.valid    = s1_valid;
        s2_d.sign     = s1_sign;
        s2_d.eff_sub  = s1_eff_sub;
        s2_d.exp_big  = s1_exp_big;
        s2_d.mant_big = s1_mant_big;
        // a difference at or past the mantissa width empties the small operand
        if (32'(s1_exp_diff) >= MANT_W) s2_d.mant_small = '0;
        else                            s2_d.mant_small = s1_mant_small >> s1_exp_diff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s2_q <= '0;
        else        s2_q <= s2_d;
    end

    assign s2_valid      = s2_q.valid;
    assign s2_sign       = s2_q.sign;
    assign s2_eff_sub    = s2_q.eff_sub;
    assign s2_exp_big    = s2_q.exp_big;
    assign s2_mant_big   = s2_q.mant_big;
    assign s2_mant_small = s2_q.mant_small;

    // R5: the aligned smaller mantissa never exceeds the larger one
    a_r5_aligned_le: assert property (@(posedge clk) disable iff (!rst_n)
        s2_q.valid |-> (s2_q.mant_small <= s2_q.mant_big));
endmodule

// File: rtl/fpa_addsub.sv
module fpa_addsub #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s2_valid,
    input  logic              s2_sign,
    input  logic              s2_eff_sub,
    input  logic [EXP_W-1:0]  s2_exp_big,
    input  logic [FRAC_W:0]   s2_mant_big,
    input  logic [FRAC_W:0]   s2_mant_small,
    output logic              s3_valid,
    output logic              s3_sign,
    output logic [EXP_W-1:0]  s3_exp,
    output logic [FRAC_W+1:0] s3_mag
);
    localparam int SUM_W = FRAC_W + 2;

    typedef struct packed {
        logic             valid;
        logic             sign;
        logic [EXP_W-1:0] exp_v;
        logic [SUM_W-1:0] mag;
    } s3_t;

    s3_t s3_d, s3_q;

    always_comb begin
        s3_d.valid = s2_valid;
        s3_d.exp_v = s2_exp_big;
        if (s2_eff_sub) s3_d.mag = {1'b0, s2_mant_big} - {1'b0, s2_mant_small};
        else            s3_d.mag = {1'b0, s2_mant_big} + {1'b0, s2_mant_small};
        s3_d.sign = (s3_d.mag == '0) ? 1'b0 : s2_sign;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s3_q <= '0;
        else        s3_q <= s3_d;
    end

    assign s3_valid = s3_q.valid;
    assign s3_sign  = s3_q.sign;
    assign s3_exp   = s3_q.exp_v;
    assign s3_mag   = s3_q.mag;

    // R6: an effective subtraction never borrows past the top
    a_r6_sub_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_valid && s2_eff_sub) |-> (s2_mant_big >= s2_mant_small));
endmodule

// File: rtl/fpa_front.sv
module fpa_front #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  op_sub,
    input  logic [EXP_W+FRAC_W:0] opa,
    input  logic [EXP_W+FRAC_W:0] opb,
    output logic                  res_valid,
    output logic                  res_sign,
    output logic [EXP_W-1:0]      res_exp,
    output logic [FRAC_W+1:0]     res_mag
);
    localparam int MANT_W = FRAC_W + 1;

    logic              s1_valid, s1_sign, s1_eff_sub;
    logic [EXP_W-1:0]  s1_exp_big, s1_exp_diff;
    logic [MANT_W-1:0] s1_mant_big, s1_mant_small;
    logic              s2_valid, s2_sign, s2_eff_sub;
    logic [EXP_W-1:0]  s2_exp_big;
    logic [MANT_W-1:0] s2_mant_big, s2_mant_small;

    fpa_cmp_swap #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
        .opa(opa), .opb(opb),
        .s1_valid(s1_valid), .s1_sign(s1_sign), .s1_eff_sub(s1_eff_sub),
        .s1_exp_big(s1_exp_big), .s1_exp_diff(s1_exp_diff),
        .s1_mant_big(s1_mant_big), .s1_mant_small(s1_mant_small)
    );

    fpa_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
        .clk(clk), .rst_n(rst_n),
        .s1_valid(s1_valid), .s1_sign(s1_sign), .s1_eff_sub(s1_eff_sub),
        .s1_exp_big(s1_exp_big), .s1_exp_diff(s1_exp_diff),
        .s1_mant_big(s1_mant_big), .s1_mant_small(s1_mant_small),
        .s2_valid(s2_valid), .s2_sign(s2_sign), .s2_eff_sub(s2_eff_sub),
        .s2_exp_big(s2_exp_big), .s2_mant_big(s2_mant_big),
        .s2_mant_small(s2_mant_small)
    );

    fpa_addsub #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_add (
        .clk(clk), .rst_n(rst_n),
        .s2_valid(s2_valid), .s2_sign(s2_sign), .s2_eff_sub(s2_eff_sub),
        .s2_exp_big(s2_exp_big), .s2_mant_big(s2_mant_big),
        .s2_mant_small(s2_mant_small),
        .s3_valid(res_valid), .s3_sign(res_sign), .s3_exp(res_exp), .s3_mag(res_mag)
    );

    // R8: every accepted pair leaves three cycles later
    a_r8_valid_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##2 res_valid);

    // R8: no result appears without an accepted pair three cycles earlier
    a_r8_valid_bwd: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(in_valid, 3));

    // R7: a zero magnitude is reported positive
    a_r7_zero_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_mag == '0) |-> !res_sign);
endmodule

// File: tb/fpa_front_tb.sv
module fpa_front_tb;
    localparam int SE = 3, SF = 3;          // small sweep configuration
    localparam int WE = 10, WF = 15;        // wide directed configuration
    localparam int SOP = 1 + SE + SF;
    localparam int WOP = 1 + WE + WF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic             in_valid = 1'b0, op_sub = 1'b0;
    logic [SOP-1:0]   opa = '0, opb = '0;
    logic             res_valid, res_sign;
    logic [SE-1:0]    res_exp;
    logic [SF+1:0]    res_mag;

    logic             w_valid = 1'b0, w_sub = 1'b0;
    logic [WOP-1:0]   w_a = '0, w_b = '0;
    logic             w_res_valid, w_res_sign;
    logic [WE-1:0]    w_res_exp;
    logic [WF+1:0]    w_res_mag;

    fpa_front #(.EXP_W(SE), .FRAC_W(SF)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
        .opa(opa), .opb(opb), .res_valid(res_valid), .res_sign(res_sign),
        .res_exp(res_exp), .res_mag(res_mag));

    fpa_front #(.EXP_W(WE), .FRAC_W(WF)) u_dut_wide (
        .clk(clk), .rst_n(rst_n), .in_valid(w_valid), .op_sub(w_sub),
        .opa(w_a), .opb(w_b), .res_valid(w_res_valid), .res_sign(w_res_sign),
        .res_exp(w_res_exp), .res_mag(w_res_mag));

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit checking = 1'b0;
    always @(posedge clk) cyc <= cyc + 1;

    // expected result from the requirements, plain integer arithmetic
    function automatic void model(input int fw, input longint sa, ea, fa,
                                  input longint sb0, eb, fb, input longint sub,
                                  output longint xs, output longint xe, output longint xm);
        longint sb, ma, mb, sl, el, ml, es, ms, d, sh;
        sb = sb0 ^ sub;                                   // R3
        ma = (ea != 0) ? ((longint'(1) << fw) | fa) : 0;  // R2
        mb = (eb != 0) ? ((longint'(1) << fw) | fb) : 0;
        if (ea > eb || (ea == eb && ma >= mb)) begin      // R4
            sl = sa; el = ea; ml = ma; es = eb; ms = mb;
        end else begin
            sl = sb; el = eb; ml = mb; es = ea; ms = ma;
        end
        d  = el - es;
        sh = (d >= fw + 1) ? 0 : (ms >> d);               // R5
        xm = (sa != sb) ? (ml - sh) : (ml + sh);          // R6
        xs = (xm == 0) ? 0 : sl;                          // R7
        xe = el;
    endfunction

    // expected-result queue for the pipelined sweep
    localparam int QD = 64;
    longint q_s[QD], q_e[QD], q_m[QD];
    int     q_t[QD];
    string  q_tag[QD];
    int wr = 0, rd = 0;

    always @(negedge clk) begin
        if (checking) begin
            if (res_valid) begin
                n_chk++;
                if (rd == wr) begin
                    n_bad++;
                    $display("FAIL R8 unexpected res_valid act=1 exp=0 at cycle %0d", cyc);
                end else begin
                    if (cyc - q_t[rd] != 3) begin
                        n_bad++;
                        $display("FAIL R8 latency act=%0d exp=3", cyc - q_t[rd]);
                    end
                    if (longint'(res_sign) != q_s[rd] || longint'(res_exp) != q_e[rd] ||
                        longint'(res_mag) != q_m[rd]) begin
                        n_bad++;
                        $display("FAIL %s act s=%0d e=%0d m=%0d exp s=%0d e=%0d m=%0d",
                                 q_tag[rd], res_sign, res_exp, res_mag, q_s[rd], q_e[rd], q_m[rd]);
                    end
                    rd = (rd + 1) % QD;
                end
            end else if (rd != wr && cyc - q_t[rd] >= 3) begin
                n_chk++; n_bad++;
                $display("FAIL R8 missing res_valid act=0 exp=1 at cycle %0d", cyc);
                rd = (rd + 1) % QD;
            end
        end
    end

    task automatic wide_vec(input logic s_a, input int e_a, input int f_a,
                            input logic s_b, input int e_b, input int f_b,
                            input logic sub, input string tag);
        longint xs, xe, xm;
        model(WF, s_a, e_a, f_a, s_b, e_b, f_b, sub, xs, xe, xm);
        @(negedge clk);
        w_a = {s_a, WE'(e_a), WF'(f_a)};
        w_b = {s_b, WE'(e_b), WF'(f_b)};
        w_sub = sub; w_valid = 1'b1;
        @(negedge clk);
        w_valid = 1'b0;
        repeat (2) @(negedge clk);
        n_chk++;
        if (!w_res_valid || longint'(w_res_sign) != xs || longint'(w_res_exp) != xe ||
            longint'(w_res_mag) != xm) begin
            n_bad++;
            $display("FAIL %s wide act v=%0d s=%0d e=%0d m=%0d exp v=1 s=%0d e=%0d m=%0d",
                     tag, w_res_valid, w_res_sign, w_res_exp, w_res_mag, xs, xe, xm);
        end
    endtask

    initial begin
        repeat (3) begin
            @(negedge clk);
            n_chk++;
            if (res_valid || w_res_valid) begin
                n_bad++;
                $display("FAIL R9 reset valid act=%0d/%0d exp=0/0", res_valid, w_res_valid);
            end
        end
        rst_n = 1'b1;
        @(negedge clk);
        checking = 1'b1;

        // exhaustive sweep of the small format, both operations
        for (int v = 0; v < (1 << (2 * SOP + 1)); v++) begin
            longint xs, xe, xm;
            logic [SOP-1:0] a, b;
            logic s;
            string tag;
            a = SOP'(v);
            b = SOP'(v >> SOP);
            s = v[2*SOP];
            if ((v % 61) == 0) begin
                // bubble: pair offered with in_valid low must not appear (R8)
                @(negedge clk);
                in_valid = 1'b0; opa = a; opb = b; op_sub = s;
            end
            model(SF, a[SOP-1], a[SOP-2 -: SE], a[SF-1:0],
                  b[SOP-1], b[SOP-2 -: SE], b[SF-1:0], s, xs, xe, xm);
            if (a[SOP-2 -: SE] == 0 || b[SOP-2 -: SE] == 0) tag = "R2";
            else if (xm == 0) tag = "R7";
            else if ((a[SOP-2 -: SE] > b[SOP-2 -: SE] ? a[SOP-2 -: SE] - b[SOP-2 -: SE]
                      : b[SOP-2 -: SE] - a[SOP-2 -: SE]) >= SF + 1) tag = "R5";
            else if (s) tag = "R3";
            else if (a[SOP-1] != b[SOP-1]) tag = "R6";
            else tag = "R4";
            @(negedge clk);
            in_valid = 1'b1; opa = a; opb = b; op_sub = s;
            q_s[wr] = xs; q_e[wr] = xe; q_m[wr] = xm; q_t[wr] = cyc; q_tag[wr] = tag;
            wr = (wr + 1) % QD;
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (6) @(negedge clk);
        checking = 1'b0;

        // R1: wide format, directed boundary cases
        wide_vec(1'b0, 511, 0,     1'b0, 511, 0,     1'b0, "R1 carry");
        wide_vec(1'b0, 511, 1234,  1'b0, 511, 1234,  1'b1, "R7 cancel");
        wide_vec(1'b0, 600, 77,    1'b1, 584, 32767, 1'b0, "R5 diff16");
        wide_vec(1'b0, 600, 77,    1'b1, 585, 32767, 1'b0, "R5 diff15");
        wide_vec(1'b1, 520, 9,     1'b0, 510, 4000,  1'b0, "R4 neg big");
        wide_vec(1'b0, 300, 5,     1'b0, 301, 100,   1'b1, "R3 sub swap");
        wide_vec(1'b0, 0,   999,   1'b1, 700, 3,     1'b0, "R2 zero");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R8 watchdog act=running exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule